// File: doc/BRIEF.md
# Bulk IN Burst Sequence Tracker

This block is the host-side receive sequencer for a high-speed bulk IN endpoint. A transfer starts with a request for a number of packets. The block then answers every data packet descriptor with one acknowledgement descriptor. Each data packet descriptor carries a sequence number, a length, a CRC-good flag and an end-of-burst flag. Each acknowledgement carries the next expected sequence number, the number of packets the host still asks for, and a retry flag. Sequence numbers are 5 bits wide and wrap modulo 32. The expected sequence number persists from one transfer to the next. The packet count advertised in an acknowledgement is capped by the endpoint's configured maximum burst.

The block detects corrupted packets and out-of-order packets. It rewinds the device to the first failing packet by issuing a retry acknowledgement, and drops any later packet that is still in flight. A device that reports it is not ready parks the endpoint until the device signals that it is ready again. A saturating counter records how many retry acknowledgements have been issued.

The controller has four states:
- `ST_IDLE`: no transfer in progress.
- `ST_SEND`: drives one acknowledgement for one cycle.
- `ST_RECV`: waits for data packets.
- `ST_FLOW`: waits for the device-ready event.

The transitions are:
- IDLE→SEND on a start with a non-zero count.
- RECV→SEND on an accepted packet or a detected error.
- RECV→FLOW on a not-ready event.
- FLOW→SEND on a ready event.
- SEND→RECV, SEND→FLOW or SEND→IDLE, following the destination that the event leading into SEND chose.
- RECV→RECV when a packet is discarded.

Top module: `bulk_in_seq_tracker`

## Requirements
- R1: After reset, `busy`, `ack_valid` and `err_count` are 0, and the expected sequence number is 0.
- R2: In idle, a `start` with a non-zero `start_nump` loads the remaining count. One cycle later it produces one acknowledgement with the expected sequence number and `ack_retry`=0. A `start` with `start_nump`=0 is ignored, and `busy` stays 0.
- R3: Every acknowledgement's `ack_nump` equals min(`cfg_max_burst`, remaining packet count).
- R4: A packet with the CRC-good flag set (`dp_crc_ok`=1) whose sequence number equals the expected value is accepted. It advances the expected value by 1 modulo 32, so 31 is followed by 0. It decrements the remaining count, and the next cycle brings an acknowledgement with `ack_retry`=0.
- R5: A packet with `dp_crc_ok`=0, or a packet with an unexpected sequence number while no retry is pending, is an error. The next cycle brings an acknowledgement that carries the unchanged expected sequence number with `ack_retry`=1. The remaining count is unchanged.
- R6: While a retry is pending, a packet whose sequence number differs from the expected value is discarded with no acknowledgement. The in-order good packet that follows clears the retry.
- R7: When the remaining count reaches 0, the acknowledgement carries `ack_nump`=0 and the block returns to idle (`busy`=0).
- R8: An accepted packet with `dp_len` below `MAX_PKT` (a short packet) ends the transfer and returns the block to idle after its acknowledgement.
- R9: An accepted packet with `dp_eob`=1 is acknowledged, and the block then waits for `erdy`. The `erdy` event produces a fresh acknowledgement.
- R10: `nrdy` while waiting for data enters flow control. No acknowledgement is produced and data packets are ignored until `erdy`, which produces one acknowledgement with the unchanged expected sequence number.
- R11: `err_count` increments by one on each detected error and saturates at its maximum value (15 by default).
- R12: `ack_valid` is a single-cycle pulse: it is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_max_burst | input | BURST_W | Endpoint maximum burst, 1 to 16 |
| start | input | 1 | Begin a transfer |
| start_nump | input | CNT_W | Packets requested for the transfer |
| dp_valid | input | 1 | Data packet descriptor present |
| dp_seq | input | SEQ_W | Data packet sequence number |
| dp_len | input | LEN_W | Data packet payload length in bytes |
| dp_crc_ok | input | 1 | Packet arrived without corruption |
| dp_eob | input | 1 | Device marks end of burst |
| nrdy | input | 1 | Device not ready |
| erdy | input | 1 | Device ready again |
| ack_valid | output | 1 | Acknowledgement descriptor present |
| ack_seq | output | SEQ_W | Next expected sequence number |
| ack_nump | output | CNT_W | Packets requested |
| ack_retry | output | 1 | Retry indication |
| busy | output | 1 | Transfer in progress |
| err_count | output | ERR_W | Saturating retry counter |

## Verification
The checker assumes three things about the inputs:
- `cfg_max_burst` stays between 1 and 16 and is steady during a transfer.
- Input events are single-cycle pulses.
- At least one quiet cycle separates events, so no packet lands in the cycle the acknowledgement is driven.

Under these assumptions a zero packet count in an acknowledgement occurs only at the end of a transfer. The stimulus drives every event for one cycle and then leaves a gap cycle, and it changes the burst limit only while the block is idle.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_RECV,
        ST_FLOW
    } bbs_state_e;
endpackage

// File: rtl/bbs_window.sv
module bbs_window #(
    parameter int BURST_W = 5,
    parameter int CNT_W   = 5
) (
    input  logic [BURST_W-1:0] max_burst,
    input  logic [CNT_W-1:0]   remaining,
    output logic [CNT_W-1:0]   nump
);
    localparam int MW = (BURST_W > CNT_W) ? BURST_W : CNT_W;

    logic [MW-1:0] burst_ext;
    logic [MW-1:0] rem_ext;
    logic [MW-1:0] pick;

    assign burst_ext = MW'(max_burst);
    assign rem_ext   = MW'(remaining);
    assign pick      = (burst_ext < rem_ext) ? burst_ext : rem_ext;
    assign nump      = pick[CNT_W-1:0];
endmodule

// File: rtl/bbs_sat_ctr.sv
module bbs_sat_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bulk_in_seq_tracker.sv
module bulk_in_seq_tracker
    import bbs_pkg::*;
#(
    parameter int SEQ_W   = 5,
    parameter int CNT_W   = 5,
    parameter int BURST_W = 5,
    parameter int MAX_PKT = 1024,
    parameter int ERR_W   = 4,
    localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BURST_W-1:0] cfg_max_burst,
    input  logic               start,
    input  logic [CNT_W-1:0]   start_nump,
    input  logic               dp_valid,
    input  logic [SEQ_W-1:0]   dp_seq,
    input  logic [LEN_W-1:0]   dp_len,
    input  logic               dp_crc_ok,
    input  logic               dp_eob,
    input  logic               nrdy,
    input  logic               erdy,
    output logic               ack_valid,
    output logic [SEQ_W-1:0]   ack_seq,
    output logic [CNT_W-1:0]   ack_nump,
    output logic               ack_retry,
    output logic               busy,
    output logic [ERR_W-1:0]   err_count
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_PKT);
    localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

    bbs_state_e       state_q, state_d;
    bbs_state_e       after_q, after_d;
    logic [SEQ_W-1:0] exp_q, exp_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             retry_q, retry_d;
    logic             err_inc;
    logic             in_order;
    logic             is_short;
    logic [CNT_W-1:0] win_nump;

    assign in_order = (dp_seq == exp_q);
    assign is_short = (dp_len < FULL_LEN);

    bbs_window #(
        .BURST_W (BURST_W),
        .CNT_W   (CNT_W)
    ) u_window (
        .max_burst (cfg_max_burst),
        .remaining (rem_q),
        .nump      (win_nump)
    );

    bbs_sat_ctr #(
        .W (ERR_W)
    ) u_err_ctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (err_inc),
        .count (err_count)
    );

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
            exp_q   <= '0;
            rem_q   <= '0;
            retry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            exp_q   <= exp_d;
            rem_q   <= rem_d;
            retry_q <= retry_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        after_d = after_q;
        exp_d   = exp_q;
        rem_d   = rem_q;
        retry_d = retry_q;
        err_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && start_nump != '0) begin
                    rem_d   = start_nump;
                    retry_d = 1'b0;
                    after_d = ST_RECV;
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                state_d = after_q;
            end
            ST_RECV: begin
                if (dp_valid) begin
                    if (retry_q && !in_order) begin
                        // late packet of a rewound burst: dropped
                        state_d = ST_RECV;
                    end else if (!dp_crc_ok || !in_order) begin
                        retry_d = 1'b1;
                        err_inc = 1'b1;
                        after_d = ST_RECV;
                        state_d = ST_SEND;
                    end else begin
                        exp_d   = exp_q + 1'b1;
                        rem_d   = rem_q - 1'b1;
                        retry_d = 1'b0;
                        state_d = ST_SEND;
                        if (rem_q == LAST_ONE || is_short) begin
                            after_d = ST_IDLE;
                        end else if (dp_eob) begin
                            after_d = ST_FLOW;
                        end else begin
                            after_d = ST_RECV;
                        end
                    end
                end else if (nrdy) begin
                    state_d = ST_FLOW;
                end
            end
            ST_FLOW: begin
                if (erdy) begin
                    after_d = ST_RECV;
                    state_d = ST_SEND;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        ack_valid = (state_q == ST_SEND);
        ack_seq   = exp_q;
        ack_nump  = win_nump;
        ack_retry = retry_q;
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/bulk_in_seq_tracker_chk.sv
module bulk_in_seq_tracker_chk #(
    parameter int CNT_W   = 5,
    parameter int BURST_W = 5,
    parameter int ERR_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [BURST_W-1:0] cfg_max_burst,
    input logic               ack_valid,
    input logic [CNT_W-1:0]   ack_nump,
    input logic               busy,
    input logic [ERR_W-1:0]   err_count
);
    // R12
    a_r12_ack_single_cycle: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid);

    // R3
    a_r3_nump_within_burst: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (32'(ack_nump) <= 32'(cfg_max_burst)));

    // R7
    a_r7_zero_nump_goes_idle: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_nump == '0) |=> !busy);

    // R11
    a_r11_err_single_step: assert property (@(posedge clk) disable iff (rst)
        (err_count != $past(err_count)) |-> (err_count == $past(err_count) + 1'b1));

    // R1
    a_r1_idle_no_ack: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ack_valid);
endmodule

bind bulk_in_seq_tracker bulk_in_seq_tracker_chk #(
    .CNT_W   (CNT_W),
    .BURST_W (BURST_W),
    .ERR_W   (ERR_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_max_burst (cfg_max_burst),
    .ack_valid     (ack_valid),
    .ack_nump      (ack_nump),
    .busy          (busy),
    .err_count     (err_count)
);

// File: tb/bulk_in_seq_tracker_tb.sv
`timescale 1ns/1ps
module bulk_in_seq_tracker_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cfg_max_burst = 5'd4;
    logic       start = 1'b0;
    logic [4:0] start_nump = '0;
    logic       dp_valid = 1'b0;
    logic [4:0] dp_seq = '0;
    logic [10:0] dp_len = '0;
    logic       dp_crc_ok = 1'b0;
    logic       dp_eob = 1'b0;
    logic       nrdy = 1'b0;
    logic       erdy = 1'b0;
    logic       ack_valid;
    logic [4:0] ack_seq;
    logic [4:0] ack_nump;
    logic       ack_retry;
    logic       busy;
    logic [3:0] err_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bulk_in_seq_tracker u_dut (
        .clk (clk), .rst (rst), .cfg_max_burst (cfg_max_burst),
        .start (start), .start_nump (start_nump),
        .dp_valid (dp_valid), .dp_seq (dp_seq), .dp_len (dp_len),
        .dp_crc_ok (dp_crc_ok), .dp_eob (dp_eob),
        .nrdy (nrdy), .erdy (erdy),
        .ack_valid (ack_valid), .ack_seq (ack_seq), .ack_nump (ack_nump),
        .ack_retry (ack_retry), .busy (busy), .err_count (err_count)
    );

    typedef struct packed {
        logic [1:0] kind;   // 0 packet, 1 nrdy, 2 erdy
        logic [4:0] seq;
        logic       shrt;
        logic       crc;
        logic       eob;
        logic       ackv;
        logic [4:0] aseq;
        logic [4:0] anump;
        logic       aretry;
        logic [3:0] err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, 5'd4, 1'b0, 4'd0},
        '{2'd0, 5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2, 5'd4, 1'b0, 4'd0},
        '{2'd0, 5'd3, 1'b0, 1'b1, 1'b0, 1'b1, 5'd2, 5'd4, 1'b1, 4'd1},
        '{2'd0, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 4'd1},
        '{2'd0, 5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2, 5'd4, 1'b1, 4'd2},
        '{2'd0, 5'd2, 1'b0, 1'b1, 1'b0, 1'b1, 5'd3, 5'd4, 1'b0, 4'd2},
        '{2'd1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 4'd2},
        '{2'd0, 5'd3, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 4'd2},
        '{2'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 5'd4, 1'b0, 4'd2},
        '{2'd0, 5'd3, 1'b0, 1'b1, 1'b1, 1'b1, 5'd4, 5'd4, 1'b0, 4'd2},
        '{2'd0, 5'd4, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 4'd2},
        '{2'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd4, 5'd4, 1'b0, 4'd2},
        '{2'd0, 5'd4, 1'b0, 1'b1, 1'b0, 1'b1, 5'd5, 5'd4, 1'b0, 4'd2},
        '{2'd0, 5'd5, 1'b0, 1'b1, 1'b0, 1'b1, 5'd6, 5'd4, 1'b0, 4'd2},
        '{2'd0, 5'd6, 1'b0, 1'b1, 1'b0, 1'b1, 5'd7, 5'd3, 1'b0, 4'd2},
        '{2'd0, 5'd7, 1'b1, 1'b1, 1'b0, 1'b1, 5'd8, 5'd2, 1'b0, 4'd2}
    };

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Ends at the negedge where the resulting acknowledgement is visible
    task automatic pkt(input logic [4:0] s, input bit shrt, input bit ok, input bit eob);
        dp_valid = 1'b1; dp_seq = s; dp_len = shrt ? 11'd100 : 11'd1024;
        dp_crc_ok = ok; dp_eob = eob;
        @(negedge clk);
        dp_valid = 1'b0; dp_crc_ok = 1'b0; dp_eob = 1'b0;
    endtask

    task automatic gap();
        @(negedge clk);
    endtask

    task automatic exp_ack(input string req, input int s, input int n, input int r);
        chk({req, " ack_valid"}, int'(ack_valid), 1);
        chk({req, " ack_seq"}, int'(ack_seq), s);
        chk({req, " ack_nump"}, int'(ack_nump), n);
        chk({req, " ack_retry"}, int'(ack_retry), r);
    endtask

    task automatic do_start(input logic [4:0] n);
        start = 1'b1; start_nump = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 ack_valid", int'(ack_valid), 0);
        chk("R1 err_count", int'(err_count), 0);

        // R2 zero-count start ignored
        do_start(5'd0);
        chk("R2 zero start busy", int'(busy), 0);
        chk("R2 zero start ack", int'(ack_valid), 0);
        gap();

        // R2/R3 start: window min(4,10)=4, seq 0 (R1)
        do_start(5'd10);
        exp_ack("R2 start", 0, 4, 0);
        gap();

        // Table: R4 R5 R6 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].kind == 2'd0) begin
                pkt(VEC[i].seq, VEC[i].shrt, VEC[i].crc, VEC[i].eob);
            end else begin
                if (VEC[i].kind == 2'd1) nrdy = 1'b1; else erdy = 1'b1;
                @(negedge clk);
                nrdy = 1'b0; erdy = 1'b0;
            end
            chk($sformatf("R4-R10 vec%0d ack_valid", i), int'(ack_valid), int'(VEC[i].ackv));
            if (VEC[i].ackv) begin
                chk($sformatf("R4 vec%0d ack_seq", i), int'(ack_seq), int'(VEC[i].aseq));
                chk($sformatf("R3 vec%0d ack_nump", i), int'(ack_nump), int'(VEC[i].anump));
                chk($sformatf("R5 vec%0d ack_retry", i), int'(ack_retry), int'(VEC[i].aretry));
            end
            chk($sformatf("R11 vec%0d err_count", i), int'(err_count), int'(VEC[i].err));
            gap();
        end
        chk("R8 short packet idle", int'(busy), 0);

        // R7 count exhaustion with burst limit 16
        cfg_max_burst = 5'd16;
        do_start(5'd2);
        exp_ack("R7 start", 8, 2, 0);
        gap();
        pkt(5'd8, 1'b0, 1'b1, 1'b0);
        exp_ack("R7 first", 9, 1, 0);
        gap();
        pkt(5'd9, 1'b0, 1'b1, 1'b0);
        exp_ack("R7 last", 10, 0, 0);
        gap();
        chk("R7 idle after zero", int'(busy), 0);

        // R4 wrap, R3 window capped by burst
        do_start(5'd25);
        exp_ack("R3 cap", 10, 16, 0);
        gap();
        for (int s = 10; s < 32; s++) begin
            pkt(5'(s), 1'b0, 1'b1, 1'b0);
            chk("R4 run seq", int'(ack_seq), (s + 1) % 32);
            gap();
        end
        pkt(5'd0, 1'b0, 1'b1, 1'b0);
        exp_ack("R4 wrap", 1, 2, 0);
        gap();

        // R11 saturation: 2 + 16 errors -> 15
        for (int k = 0; k < 16; k++) begin
            pkt(5'd1, 1'b0, 1'b0, 1'b0);
            chk("R5 repeat retry", int'(ack_retry), 1);
            gap();
        end
        chk("R11 saturated", int'(err_count), 15);
        pkt(5'd1, 1'b0, 1'b1, 1'b0);
        exp_ack("R6 retry cleared", 2, 1, 0);
        gap();
        pkt(5'd2, 1'b0, 1'b1, 1'b0);
        exp_ack("R7 final", 3, 0, 0);
        gap();
        chk("R7 idle end", int'(busy), 0);
        chk("R11 held", int'(err_count), 15);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule